// File: doc/BRIEF.md
# Physical Register Scoreboard with Wakeup Window

This block keeps one ready bit for every renamed physical register and holds a small window of instructions that wait for their source operands. When an instruction enters the window, each source is resolved at once. A source counts as ready if the sender already flagged it ready, if its index lies outside the tracked register range, if the scoreboard bit is already set, or if a completion for that register arrives in the same cycle. Any other source waits on its register tag. Each destination of the inserted instruction clears its scoreboard bit, and the instruction becomes that register's producer.

Finished instructions broadcast their destination indices on a completion port that carries several results per cycle. Each broadcast sets the scoreboard bit and wakes every waiting source whose tag matches. An entry reports ready-to-issue once all of its sources are ready. The squash port drops an entry; its pending tag claims go with it. Inserting a producer for a register that still has live waiters raises a fatal-error pulse.

The allocator outside the block picks the window slots. The same squash port is used to release a slot after issue.

Top module: `psb_scoreboard`

## Requirements
- R1: After reset every scoreboard bit reads 0 (not ready), every entry is invalid with all source-ready bits 0, no entry is ready to issue, and the error output is 0.
- R2: On insertion into slot `ins_slot`, source s (bits `[s*IDX_W +: IDX_W]` of `ins_src_idx`; ready flag `ins_src_rdy[s]`) reads ready in `ent_src_rdy[slot*NUM_SRC+s]` from the next cycle if any of these holds: its flag is set, its index is at least NPREG, or its scoreboard bit was already set. Otherwise it reads 0 and waits on that register.
- R3: Each inserted destination whose index is below NPREG clears its bit in `reg_ready` from the next cycle.
- R4: A destination index at or above NPREG changes no scoreboard bit and never raises `prod_err`.
- R5: A completion with an in-range index sets that register's scoreboard bit. In the same step it marks ready every valid waiting source with that tag; both changes are visible one cycle later. Out-of-range completion indices are ignored.
- R6: Up to NUM_CMP completions in one cycle are all applied.
- R7: `ent_issue_rdy[e]` is 1 exactly when entry e is valid and all its source-ready bits are 1.
- R8: A source inserted in the same cycle as a completion of its register is ready from the next cycle.
- R9: If a completion and an insertion destination name the same register in one cycle, the insertion wins and the bit reads 0.
- R10: A squashed entry reads invalid, with its source-ready bits 0, from the next cycle. Later completions do not revive it, and its pending sources no longer count as waiters.
- R11: `prod_err` pulses one cycle after an insertion whose in-range destination has at least one waiter. A waiter here is a valid, not-squashed entry holding a not-ready source with that tag. No pulse occurs if a completion of that register arrives in the same cycle.
- R12: When insertion and squash name the same slot in one cycle, the insertion wins and the entry is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert an instruction this cycle |
| ins_slot | input | SLOT_W | Window slot to fill |
| ins_src_idx | input | NUM_SRC*IDX_W | Source register indices, source s at `[s*IDX_W +: IDX_W]` |
| ins_src_rdy | input | NUM_SRC | Per-source ready flag from upstream |
| ins_dst_idx | input | NUM_DST*IDX_W | Destination register indices |
| cmp_vld | input | NUM_CMP | Completion broadcast valid, one bit per lane |
| cmp_idx | input | NUM_CMP*IDX_W | Completed destination indices, lane k at `[k*IDX_W +: IDX_W]` |
| sq_valid | input | 1 | Remove an entry this cycle |
| sq_slot | input | SLOT_W | Slot to remove |
| reg_ready | output | NPREG | Scoreboard ready bits |
| ent_valid | output | NUM_ENT | Entry occupied |
| ent_src_rdy | output | NUM_ENT*NUM_SRC | Per-entry, per-source ready |
| ent_issue_rdy | output | NUM_ENT | Entry ready to issue |
| prod_err | output | 1 | Producer inserted over live waiters |

## Verification
Several properties are checked on every cycle by assertions:
- a loaded entry becomes valid;
- a squash without a load empties its entry;
- a ready source stays ready while its entry is held;
- an in-range destination always leaves its bit cleared;
- an insertion with no in-range destination never produces an error.

Other behaviours only show up in the bench's scenarios, which compare against a reference model:
- same-cycle interplay between a completion and an insertion of the same register, for both sources and destinations;
- multi-lane completions;
- the fact that squashed waiters no longer block a new producer;
- ignoring out-of-range indices.

// File: rtl/psb_pkg.sv
package psb_pkg;

   localparam int unsigned PSB_IDX_W_DEFAULT = 6;

   // Register index tracked by the scoreboard when below the physical count.
   function automatic logic idx_in_range(input logic [31:0] idx, input int unsigned npreg);
      return (idx < npreg);
   endfunction

   // Source state held in a window entry.
   typedef enum logic {
      SRC_WAITING = 1'b0,
      SRC_READY   = 1'b1
   } src_state_e;

endpackage

// File: rtl/psb_ready_bits.sv
module psb_ready_bits #(
   parameter int unsigned NPREG  = 32,
   parameter int unsigned PREG_W = 5,
   parameter int unsigned NSET   = 2,
   parameter int unsigned NCLR   = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NSET-1:0]          set_vld,
   input  logic [NSET*PREG_W-1:0]   set_idx,
   input  logic [NCLR-1:0]          clr_vld,
   input  logic [NCLR*PREG_W-1:0]   clr_idx,
   output logic [NPREG-1:0]         bits
);

   logic [NPREG-1:0] bits_q;
   logic [NPREG-1:0] bits_d;

   // Completions set first, then insertion destinations clear (insert wins).
   always_comb begin
      bits_d = bits_q;
      for (int k = 0; k < NSET; k++) begin
         if (set_vld[k]) bits_d[set_idx[k*PREG_W +: PREG_W]] = 1'b1;
      end
      for (int d = 0; d < NCLR; d++) begin
         if (clr_vld[d]) bits_d[clr_idx[d*PREG_W +: PREG_W]] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) bits_q <= '0;
      else        bits_q <= bits_d;
   end

   assign bits = bits_q;

   for (genvar d = 0; d < NCLR; d++) begin : g_clr_chk
      AST_DST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         clr_vld[d] |=> !bits_q[$past(clr_idx[d*PREG_W +: PREG_W])]); // R3
   end

endmodule

// File: rtl/psb_src_resolve.sv
module psb_src_resolve #(
   parameter int unsigned NPREG   = 32,
   parameter int unsigned PREG_W  = 5,
   parameter int unsigned IDX_W   = 6,
   parameter int unsigned NUM_SRC = 2,
   parameter int unsigned NUM_CMP = 2
) (
   input  logic [NUM_SRC*IDX_W-1:0] src_idx,
   input  logic [NUM_SRC-1:0]       src_flag,
   input  logic [NPREG-1:0]         sb_bits,
   input  logic [NUM_CMP-1:0]       cmp_live,
   input  logic [NUM_CMP*IDX_W-1:0] cmp_idx,
   output logic [NUM_SRC-1:0]       src_rdy
);

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      logic [IDX_W-1:0] idx;
      logic             in_rng;
      logic             sb_hit;
      logic             cmp_hit;

      assign idx    = src_idx[s*IDX_W +: IDX_W];
      assign in_rng = psb_pkg::idx_in_range(32'(idx), NPREG);
      assign sb_hit = in_rng && sb_bits[idx[PREG_W-1:0]];

      always_comb begin
         cmp_hit = 1'b0;
         for (int k = 0; k < NUM_CMP; k++) begin
            if (cmp_live[k] && (cmp_idx[k*IDX_W +: IDX_W] == idx)) cmp_hit = 1'b1;
         end
      end

      assign src_rdy[s] = src_flag[s] || !in_rng || sb_hit || cmp_hit;
   end

endmodule

// File: rtl/psb_wait_entry.sv
module psb_wait_entry #(
   parameter int unsigned IDX_W   = 6,
   parameter int unsigned NUM_SRC = 2,
   parameter int unsigned NUM_DST = 1,
   parameter int unsigned NUM_CMP = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic                     squash,
   input  logic [NUM_SRC*IDX_W-1:0] ld_tags,
   input  logic [NUM_SRC-1:0]       ld_rdy,
   input  logic [NUM_CMP-1:0]       cmp_live,
   input  logic [NUM_CMP*IDX_W-1:0] cmp_tags,
   input  logic [NUM_DST*IDX_W-1:0] probe_tags,
   output logic                     valid,
   output logic [NUM_SRC-1:0]       src_rdy,
   output logic                     issue_rdy,
   output logic [NUM_DST-1:0]       probe_hit
);

   logic [NUM_SRC*IDX_W-1:0] tags_q;
   logic [NUM_SRC-1:0]       wake;

   always_comb begin
      for (int s = 0; s < NUM_SRC; s++) begin
         wake[s] = 1'b0;
         for (int k = 0; k < NUM_CMP; k++) begin
            if (cmp_live[k] && (cmp_tags[k*IDX_W +: IDX_W] == tags_q[s*IDX_W +: IDX_W]))
               wake[s] = 1'b1;
         end
      end
   end

   // A pending source of a surviving entry counts as a waiter.
   always_comb begin
      for (int d = 0; d < NUM_DST; d++) begin
         probe_hit[d] = 1'b0;
         if (valid && !squash) begin
            for (int s = 0; s < NUM_SRC; s++) begin
               if (!src_rdy[s] && (tags_q[s*IDX_W +: IDX_W] == probe_tags[d*IDX_W +: IDX_W]))
                  probe_hit[d] = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid   <= 1'b0;
         src_rdy <= '0;
         tags_q  <= '0;
      end else if (load) begin
         valid   <= 1'b1;
         src_rdy <= ld_rdy;
         tags_q  <= ld_tags;
      end else if (squash) begin
         valid   <= 1'b0;
         src_rdy <= '0;
      end else if (valid) begin
         src_rdy <= src_rdy | wake;
      end
   end

   assign issue_rdy = valid && (&src_rdy);

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> valid); // R12

   AST_SQUASH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (squash && !load) |=> (!valid && (src_rdy == '0))); // R10

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_hold
      AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (valid && src_rdy[s] && !load && !squash) |=> src_rdy[s]); // R5
   end

endmodule

// File: rtl/psb_scoreboard.sv
module psb_scoreboard #(
   parameter int unsigned NUM_INT_PREGS = 16,
   parameter int unsigned NUM_FP_PREGS  = 16,
   parameter int unsigned IDX_W         = psb_pkg::PSB_IDX_W_DEFAULT,
   parameter int unsigned NUM_SRC       = 2,
   parameter int unsigned NUM_DST       = 1,
   parameter int unsigned NUM_ENT       = 8,
   parameter int unsigned NUM_CMP       = 2,
   localparam int unsigned NPREG        = NUM_INT_PREGS + NUM_FP_PREGS,
   localparam int unsigned PREG_W       = (NPREG > 1) ? $clog2(NPREG) : 1,
   localparam int unsigned SLOT_W       = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        ins_valid,
   input  logic [SLOT_W-1:0]           ins_slot,
   input  logic [NUM_SRC*IDX_W-1:0]    ins_src_idx,
   input  logic [NUM_SRC-1:0]          ins_src_rdy,
   input  logic [NUM_DST*IDX_W-1:0]    ins_dst_idx,
   input  logic [NUM_CMP-1:0]          cmp_vld,
   input  logic [NUM_CMP*IDX_W-1:0]    cmp_idx,
   input  logic                        sq_valid,
   input  logic [SLOT_W-1:0]           sq_slot,
   output logic [NPREG-1:0]            reg_ready,
   output logic [NUM_ENT-1:0]          ent_valid,
   output logic [NUM_ENT*NUM_SRC-1:0]  ent_src_rdy,
   output logic [NUM_ENT-1:0]          ent_issue_rdy,
   output logic                        prod_err
);

   if (IDX_W < PREG_W || IDX_W > 32) begin : g_bad_idx_w
      $error("psb_scoreboard: IDX_W must cover the register count and fit 32 bits");
   end
   if (NUM_SRC < 1 || NUM_DST < 1 || NUM_CMP < 1 || NUM_ENT < 1) begin : g_bad_count
      $error("psb_scoreboard: port and entry counts must be at least one");
   end

   logic [NUM_CMP-1:0]         cmp_live;
   logic [NUM_CMP*PREG_W-1:0]  cmp_short;
   logic [NUM_DST-1:0]         dst_live;
   logic [NUM_DST-1:0]         dst_done;
   logic [NUM_DST*PREG_W-1:0]  dst_short;
   logic [NUM_SRC-1:0]         ins_resolved;
   logic [NUM_ENT*NUM_DST-1:0] probe_hits;
   logic [NUM_DST-1:0]         waiter_any;
   logic                       err_d;

   for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
      assign cmp_live[k] = cmp_vld[k]
                        && psb_pkg::idx_in_range(32'(cmp_idx[k*IDX_W +: IDX_W]), NPREG);
      assign cmp_short[k*PREG_W +: PREG_W] = cmp_idx[k*IDX_W +: PREG_W];
   end

   for (genvar d = 0; d < NUM_DST; d++) begin : g_dst
      logic [IDX_W-1:0] didx;
      assign didx = ins_dst_idx[d*IDX_W +: IDX_W];
      assign dst_live[d] = ins_valid && psb_pkg::idx_in_range(32'(didx), NPREG);
      assign dst_short[d*PREG_W +: PREG_W] = didx[PREG_W-1:0];
      always_comb begin
         dst_done[d] = 1'b0;
         for (int k = 0; k < NUM_CMP; k++) begin
            if (cmp_live[k] && (cmp_idx[k*IDX_W +: IDX_W] == didx)) dst_done[d] = 1'b1;
         end
      end
   end

   psb_ready_bits #(
      .NPREG(NPREG), .PREG_W(PREG_W), .NSET(NUM_CMP), .NCLR(NUM_DST)
   ) u_bits (
      .clk(clk), .rst_n(rst_n),
      .set_vld(cmp_live), .set_idx(cmp_short),
      .clr_vld(dst_live), .clr_idx(dst_short),
      .bits(reg_ready)
   );

   psb_src_resolve #(
      .NPREG(NPREG), .PREG_W(PREG_W), .IDX_W(IDX_W),
      .NUM_SRC(NUM_SRC), .NUM_CMP(NUM_CMP)
   ) u_resolve (
      .src_idx(ins_src_idx), .src_flag(ins_src_rdy), .sb_bits(reg_ready),
      .cmp_live(cmp_live), .cmp_idx(cmp_idx), .src_rdy(ins_resolved)
   );

   for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
      logic ld_e;
      logic sq_e;
      assign ld_e = ins_valid && (ins_slot == SLOT_W'(e));
      assign sq_e = sq_valid  && (sq_slot  == SLOT_W'(e));

      psb_wait_entry #(
         .IDX_W(IDX_W), .NUM_SRC(NUM_SRC), .NUM_DST(NUM_DST), .NUM_CMP(NUM_CMP)
      ) u_entry (
         .clk(clk), .rst_n(rst_n),
         .load(ld_e), .squash(sq_e),
         .ld_tags(ins_src_idx), .ld_rdy(ins_resolved),
         .cmp_live(cmp_live), .cmp_tags(cmp_idx),
         .probe_tags(ins_dst_idx),
         .valid(ent_valid[e]),
         .src_rdy(ent_src_rdy[e*NUM_SRC +: NUM_SRC]),
         .issue_rdy(ent_issue_rdy[e]),
         .probe_hit(probe_hits[e*NUM_DST +: NUM_DST])
      );
   end

   always_comb begin
      waiter_any = '0;
      for (int e = 0; e < NUM_ENT; e++) begin
         waiter_any = waiter_any | probe_hits[e*NUM_DST +: NUM_DST];
      end
      err_d = |(dst_live & ~dst_done & waiter_any);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prod_err <= 1'b0;
      else        prod_err <= err_d;
   end

   AST_NO_ERR_WITHOUT_DST: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_live == '0) |=> !prod_err); // R4

endmodule

// File: tb/sim_psb_scoreboard.sv
module sim_psb_scoreboard;

   localparam int CLK_PERIOD = 10;
   localparam int NPREG = 32;
   localparam int IDX_W = 6;
   localparam int NS = 2;
   localparam int ND = 1;
   localparam int NE = 8;
   localparam int NC = 2;
   localparam int SW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic              ins_valid;
   logic [SW-1:0]     ins_slot;
   logic [NS*IDX_W-1:0] ins_src_idx;
   logic [NS-1:0]     ins_src_rdy;
   logic [ND*IDX_W-1:0] ins_dst_idx;
   logic [NC-1:0]     cmp_vld;
   logic [NC*IDX_W-1:0] cmp_idx;
   logic              sq_valid;
   logic [SW-1:0]     sq_slot;
   logic [NPREG-1:0]  reg_ready;
   logic [NE-1:0]     ent_valid;
   logic [NE*NS-1:0]  ent_src_rdy;
   logic [NE-1:0]     ent_issue_rdy;
   logic              prod_err;

   psb_scoreboard u0 (
      .clk(clk), .rst_n(rst_n),
      .ins_valid(ins_valid), .ins_slot(ins_slot), .ins_src_idx(ins_src_idx),
      .ins_src_rdy(ins_src_rdy), .ins_dst_idx(ins_dst_idx),
      .cmp_vld(cmp_vld), .cmp_idx(cmp_idx),
      .sq_valid(sq_valid), .sq_slot(sq_slot),
      .reg_ready(reg_ready), .ent_valid(ent_valid), .ent_src_rdy(ent_src_rdy),
      .ent_issue_rdy(ent_issue_rdy), .prod_err(prod_err)
   );

   int n_chk = 0;
   int n_fail = 0;

   // Reference model state
   bit m_sb [NPREG];
   bit m_v  [NE];
   bit m_r  [NE][NS];
   int m_t  [NE][NS];
   bit m_err;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic bit cmp_hits(input int idx);
      for (int k = 0; k < NC; k++)
         if (cmp_vld[k] && int'(cmp_idx[k*IDX_W +: IDX_W]) < NPREG
             && int'(cmp_idx[k*IDX_W +: IDX_W]) == idx) return 1'b1;
      return 1'b0;
   endfunction

   // Applies the requirement rules to the inputs present at this edge.
   task automatic model_step();
      bit nsb [NPREG];
      bit err;
      err = 1'b0;
      if (ins_valid) begin
         for (int d = 0; d < ND; d++) begin
            int di = int'(ins_dst_idx[d*IDX_W +: IDX_W]);
            if (di < NPREG && !cmp_hits(di)) begin
               for (int e = 0; e < NE; e++) begin
                  if (m_v[e] && !(sq_valid && int'(sq_slot) == e))
                     for (int s = 0; s < NS; s++)
                        if (!m_r[e][s] && m_t[e][s] == di) err = 1'b1;
               end
            end
         end
      end
      for (int e = 0; e < NE; e++) begin
         if (ins_valid && int'(ins_slot) == e) begin
            m_v[e] = 1'b1;
            for (int s = 0; s < NS; s++) begin
               int si = int'(ins_src_idx[s*IDX_W +: IDX_W]);
               m_t[e][s] = si;
               m_r[e][s] = ins_src_rdy[s] || si >= NPREG || (si < NPREG && m_sb[si]) || cmp_hits(si);
            end
         end else if (sq_valid && int'(sq_slot) == e) begin
            m_v[e] = 1'b0;
            for (int s = 0; s < NS; s++) m_r[e][s] = 1'b0;
         end else if (m_v[e]) begin
            for (int s = 0; s < NS; s++) if (cmp_hits(m_t[e][s])) m_r[e][s] = 1'b1;
         end
      end
      for (int r = 0; r < NPREG; r++) nsb[r] = m_sb[r] || cmp_hits(r);
      if (ins_valid)
         for (int d = 0; d < ND; d++) begin
            int di = int'(ins_dst_idx[d*IDX_W +: IDX_W]);
            if (di < NPREG) nsb[di] = 1'b0;
         end
      m_sb = nsb;
      m_err = err;
   endtask

   task automatic compare_all(input string tag);
      logic [63:0] e_sb, e_v, e_r, e_i;
      e_sb = '0; e_v = '0; e_r = '0; e_i = '0;
      for (int r = 0; r < NPREG; r++) e_sb[r] = m_sb[r];
      for (int e = 0; e < NE; e++) begin
         bit all;
         all = 1'b1;
         e_v[e] = m_v[e];
         for (int s = 0; s < NS; s++) begin
            e_r[e*NS+s] = m_r[e][s];
            all = all && m_r[e][s];
         end
         e_i[e] = m_v[e] && all;
      end
      chk({tag, " reg_ready"},     64'(reg_ready),     e_sb);
      chk({tag, " ent_valid"},     64'(ent_valid),     e_v);
      chk({tag, " ent_src_rdy"},   64'(ent_src_rdy),   e_r);
      chk({tag, " ent_issue_rdy R7"}, 64'(ent_issue_rdy), e_i);
      chk({tag, " prod_err"},      64'(prod_err),      64'(m_err));
   endtask

   task automatic idle();
      ins_valid = 1'b0; ins_slot = '0; ins_src_idx = '0; ins_src_rdy = '0;
      ins_dst_idx = '0; cmp_vld = '0; cmp_idx = '0; sq_valid = 1'b0; sq_slot = '0;
   endtask

   task automatic set_ins(input int slot, input int s0, input int s1,
                          input bit f0, input bit f1, input int dst);
      ins_valid = 1'b1; ins_slot = SW'(slot);
      ins_src_idx = {IDX_W'(s1), IDX_W'(s0)};
      ins_src_rdy = {f1, f0};
      ins_dst_idx = IDX_W'(dst);
   endtask

   task automatic set_cmp(input int lane, input int idx);
      cmp_vld[lane] = 1'b1;
      cmp_idx[lane*IDX_W +: IDX_W] = IDX_W'(idx);
   endtask

   // One edge: model follows the edge, outputs are compared at the falling edge.
   task automatic step(input string tag);
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_all(tag);
      idle();
   endtask

   initial begin
      #(CLK_PERIOD * 60000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      idle();
      for (int r = 0; r < NPREG; r++) m_sb[r] = 1'b0;
      for (int e = 0; e < NE; e++) begin
         m_v[e] = 1'b0;
         for (int s = 0; s < NS; s++) begin m_r[e][s] = 1'b0; m_t[e][s] = 0; end
      end
      m_err = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare_all("R1 reset");
      chk("R1 scoreboard cleared", 64'(reg_ready), 64'd0);

      // R2: source 5 waits, source 40 is out of range and ready
      set_ins(0, 5, 40, 1'b0, 1'b0, 10);
      step("R2 insert");
      chk("R2 slot0 sources", 64'(ent_src_rdy[1:0]), 64'b10);

      // R5/R7: completion of 5 wakes slot 0
      set_cmp(0, 5);
      step("R5 wake");
      chk("R5 reg5 set", 64'(reg_ready[5]), 64'd1);
      chk("R7 slot0 issue", 64'(ent_issue_rdy[0]), 64'd1);

      // R2 via scoreboard, R3 destination clears reg 5
      set_ins(1, 5, 10, 1'b0, 1'b0, 5);
      step("R3 insert");
      chk("R3 reg5 cleared", 64'(reg_ready[5]), 64'd0);
      chk("R2 slot1 src0 from scoreboard", 64'(ent_src_rdy[2]), 64'd1);

      // R8, R6, R4: same-cycle completions of 10 and 11, out-of-range destination
      set_ins(2, 10, 11, 1'b0, 1'b0, 60);
      set_cmp(0, 10);
      set_cmp(1, 11);
      step("R6 dual completion");
      chk("R8 slot2 sources", 64'(ent_src_rdy[5:4]), 64'b11);
      chk("R6 slot1 woken", 64'(ent_issue_rdy[1]), 64'd1);
      chk("R4 no error", 64'(prod_err), 64'd0);

      // R11: waiter on 12, then producer of 12
      set_ins(3, 12, 12, 1'b0, 1'b0, 63);
      step("R11 waiter");
      set_ins(4, 1, 2, 1'b1, 1'b1, 12);
      step("R11 producer");
      chk("R11 error pulse", 64'(prod_err), 64'd1);

      // R10: squash the waiter while inserting another producer of 12
      sq_valid = 1'b1; sq_slot = 3'd3;
      set_ins(5, 1, 2, 1'b1, 1'b1, 12);
      step("R10 squash");
      chk("R10 no error after squash", 64'(prod_err), 64'd0);
      chk("R10 slot3 invalid", 64'(ent_valid[3]), 64'd0);
      set_cmp(0, 12);
      step("R10 no revive");
      chk("R10 slot3 stays empty", 64'(ent_src_rdy[7:6]), 64'b00);

      // R9: completion and insertion destination on 13
      set_cmp(1, 13);
      set_ins(6, 1, 2, 1'b1, 1'b1, 13);
      step("R9 insert wins");
      chk("R9 reg13 not ready", 64'(reg_ready[13]), 64'd0);

      // R12: insert and squash the same slot
      sq_valid = 1'b1; sq_slot = 3'd7;
      set_ins(7, 20, 21, 1'b0, 1'b0, 22);
      step("R12 same slot");
      chk("R12 slot7 valid", 64'(ent_valid[7]), 64'd1);

      // R5: out-of-range completion is ignored
      set_cmp(0, 45);
      step("R5 ignored completion");
      chk("R5 slot7 still waits", 64'(ent_src_rdy[15:14]), 64'b00);

      // Random mix against the model
      for (int n = 0; n < 1500; n++) begin
         if ($urandom % 3 != 0)
            set_ins(int'($urandom % NE), int'($urandom % 40), int'($urandom % 40),
                    ($urandom % 5) == 0, ($urandom % 5) == 0, int'($urandom % 36));
         for (int k = 0; k < NC; k++)
            if ($urandom % 2 == 0) set_cmp(k, int'($urandom % 34));
         if ($urandom % 4 == 0) begin
            sq_valid = 1'b1; sq_slot = SW'($urandom % NE);
         end
         step("R2/R5/R6/R11 random");
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule